// File: doc/BRIEF.md
# Four-Bit Word Rotator and Single-Step Shifter

This block reshapes a four-bit data word without any storage. Each output bit is produced by one 4:1 multiplexer steered by a two-bit select. A single mode input decides what the select means, by choosing which data bits are wired to each multiplexer's four inputs.

In rotate mode the select is a distance: the word turns toward the most significant end by that many places, and bits leaving the top re-enter at the bottom. In shift mode the select is an operation code. Codes 0 and 1 leave the word unchanged, code 2 moves every bit up by one place, and code 3 moves every bit down by one place. The bit pushed off the end is dropped, and the empty end receives a zero. The output follows the inputs combinationally, so it can sit directly on a datapath between two register stages.

Top module: `word_shift_rotate`

## Requirements
- R1: With mode = 0 (rotate), output bit i equals input bit (i - sel) mod 4 for every data word and every select value.
- R2: With mode = 0 and sel = 0 the output equals the input. With sel = 2 the output, written from bit 3 down to bit 0, is input bits 1, 0, 3, 2.
- R3: With mode = 1 (shift) and sel = 0 or sel = 1 (sel bit 1 low), the output equals the input.
- R4: With mode = 1 and sel = 2, output bit i equals input bit i-1 for i = 1..3.
- R5: With mode = 1 and sel = 3, output bit i equals input bit i+1 for i = 0..2.
- R6: In shift mode the vacated end is filled with zero: output bit 0 is 0 for sel = 2, and output bit 3 is 0 for sel = 3. The bit shifted off the other end does not appear anywhere in the output.
- R7: In rotate mode the number of ones in the output equals the number of ones in the input.
- R8: The output has no state. A change on any input shows at the output in the same time step, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 4 | Data word to be moved |
| sel | input | 2 | Rotate distance (mode 0) or operation code (mode 1) |
| mode | input | 1 | 0 selects rotate, 1 selects shift with zero fill |
| dout | output | 4 | Rotated or shifted word |

## Verification
The case most easily missed is a shift in which the bit pushed off the end is a one while its neighbour is a zero. Only that pattern shows whether the dropped bit leaks into the zero-filled position, or whether a shift has been wired as a rotate. A full sweep of all 128 input combinations contains those patterns. Directed words with a single one at an end, followed by seeded random words, put them at the edges once more. A final check changes the inputs between clock edges and reads the output before the next edge, which shows that nothing in the path is registered.

// File: rtl/word_shift_pkg.sv
package word_shift_pkg;
    localparam int WORD_W = 4;
    localparam int SEL_W  = $clog2(WORD_W);

    typedef enum logic {
        MODE_ROTATE  = 1'b0,
        MODE_ROLLOUT = 1'b1
    } move_mode_e;

    // operation codes used in rollout mode
    localparam logic [SEL_W-1:0] OP_LEFT  = 2'd2;
    localparam logic [SEL_W-1:0] OP_RIGHT = 2'd3;
endpackage

// File: rtl/lane_mux.sv
module lane_mux #(
    parameter int N     = 4,
    parameter int SEL_W = $clog2(N)
) (
    input  logic [N-1:0]     legs,
    input  logic [SEL_W-1:0] pick,
    output logic             y
);
    logic [N-1:0] onehot;

    // decoder followed by AND-OR selection
    always_comb begin
        onehot = '0;
        onehot[pick] = 1'b1;
    end

    assign y = |(legs & onehot);
endmodule

// File: rtl/lane_wiring.sv
module lane_wiring
    import word_shift_pkg::*;
#(
    parameter int W    = WORD_W,
    parameter int LANE = 0
) (
    input  logic [W-1:0] din,
    input  move_mode_e   mode,
    output logic [W-1:0] legs
);
    logic [W-1:0] rot_legs;
    logic [W-1:0] sh_legs;

    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_leg
            // rotate: leg k carries the bit k places below this lane
            assign rot_legs[k] = din[(LANE - k + W) % W];
            if (k == 2) begin : g_left
                if (LANE > 0) begin : g_src
                    assign sh_legs[k] = din[LANE - 1];
                end else begin : g_fill
                    assign sh_legs[k] = 1'b0;
                end
            end else if (k == 3) begin : g_right
                if (LANE < W - 1) begin : g_src
                    assign sh_legs[k] = din[LANE + 1];
                end else begin : g_fill
                    assign sh_legs[k] = 1'b0;
                end
            end else begin : g_pass
                assign sh_legs[k] = din[LANE];
            end
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_ROTATE:  legs = rot_legs;
            MODE_ROLLOUT: legs = sh_legs;
            default:      legs = rot_legs;
        endcase
    end
endmodule

// File: rtl/word_shift_rotate.sv
module word_shift_rotate
    import word_shift_pkg::*;
(
    input  logic [WORD_W-1:0] din,
    input  logic [SEL_W-1:0]  sel,
    input  logic              mode,
    output logic [WORD_W-1:0] dout
);
    move_mode_e mode_e;
    assign mode_e = move_mode_e'(mode);

    genvar j;
    generate
        for (j = 0; j < WORD_W; j++) begin : g_lane
            logic [WORD_W-1:0] legs;
            lane_wiring #(.W(WORD_W), .LANE(j)) u_wire (
                .din  (din),
                .mode (mode_e),
                .legs (legs)
            );
            lane_mux #(.N(WORD_W), .SEL_W(SEL_W)) u_mux (
                .legs (legs),
                .pick (sel),
                .y    (dout[j])
            );
        end
    endgenerate

    always_comb begin
        if (!$isunknown({din, sel, mode, dout})) begin
            // R2
            rot_zero_chk: assert (!(mode == 1'b0 && sel == 2'd0) || dout == din);
            // R3
            pass_thru_chk: assert (!(mode == 1'b1 && sel[1] == 1'b0) || dout == din);
            // R4
            left_move_chk: assert (!(mode == 1'b1 && sel == OP_LEFT) || dout[3:1] == din[2:0]);
            // R5
            right_move_chk: assert (!(mode == 1'b1 && sel == OP_RIGHT) || dout[2:0] == din[3:1]);
            // R6
            zero_fill_chk: assert (!(mode == 1'b1 && sel == OP_LEFT && dout[0]) &&
                                   !(mode == 1'b1 && sel == OP_RIGHT && dout[3]));
            // R7
            ones_kept_chk: assert (mode == 1'b1 || $countones(dout) == $countones(din));
        end
    end
endmodule

// File: tb/test_word_shift_rotate.sv
module test_word_shift_rotate;
    logic       clk = 1'b0;
    logic [3:0] din = '0;
    logic [1:0] sel = '0;
    logic       mode = 1'b0;
    logic [3:0] dout;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    word_shift_rotate i_word_shift_rotate (
        .din(din), .sel(sel), .mode(mode), .dout(dout)
    );

    function automatic logic [3:0] model(input logic [3:0] a, input logic [1:0] s, input logic m);
        logic [3:0] r;
        if (!m) begin
            for (int i = 0; i < 4; i++) r[i] = a[(i - s + 4) % 4];
        end else begin
            case (s)
                2'd2:    r = {a[2:0], 1'b0};
                2'd3:    r = {1'b0, a[3:1]};
                default: r = a;
            endcase
        end
        return r;
    endfunction

    function automatic string tag(input logic [1:0] s, input logic m);
        if (!m) return (s == 0 || s == 2) ? "R2" : "R1";
        if (!s[1]) return "R3";
        return (s == 2) ? "R4" : "R5";
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: din=%b sel=%0d mode=%0b actual=%b expected=%b",
                     req, din, sel, mode, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] a, input logic [1:0] s, input logic m);
        @(negedge clk);
        din = a; sel = s; mode = m;
        #1;
        check(tag(s, m), dout, model(a, s, m));
        if (!m) check("R7", 4'($countones(dout)), 4'($countones(a)));
        if (m && s == 2'd2) check("R6", {3'b0, dout[0]}, 4'b0);
        if (m && s == 2'd3) check("R6", {3'b0, dout[3]}, 4'b0);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [3:0] r;
        seed = 32'd1234;
        r = 4'($urandom(seed));
        // idle state: zero word in rotate mode gives zero out (R1)
        @(negedge clk); #1;
        check("R1", dout, 4'b0000);
        // directed: R2 half swap
        apply(4'b0011, 2'd2, 1'b0);
        check("R2", dout, 4'b1100);
        // directed end bits, R6 dropped bit must not leak
        apply(4'b1000, 2'd2, 1'b1);
        check("R6", dout, 4'b0000);
        apply(4'b0001, 2'd3, 1'b1);
        check("R6", dout, 4'b0000);
        apply(4'b1000, 2'd1, 1'b0);
        check("R1", dout, 4'b0001);
        // exhaustive sweep
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++)
                for (int a = 0; a < 16; a++)
                    apply(4'(a), 2'(s), 1'(m));
        // seeded random
        for (int n = 0; n < 200; n++) begin
            r = 4'($urandom);
            apply(r, 2'($urandom), 1'($urandom));
        end
        // R8: change inputs mid-cycle, output follows without an edge
        @(posedge clk); #3;
        din = 4'b0110; sel = 2'd1; mode = 1'b0;
        #1;
        check("R8", dout, 4'b1100);
        din = 4'b0110; sel = 2'd3; mode = 1'b1;
        #1;
        check("R8", dout, 4'b0011);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule